// File: doc/BRIEF.md
# General-Purpose Input Event Router

This block watches sixteen general-purpose input pins and latches an event for each pin on its rising edge while the pin is configured as an input. Each latched event is steered by its own 2-bit route code, either to a system-management interrupt (SMI) level or to a system-control interrupt (SCI) level. Each route is gated by a separate per-input enable. The SMI path uses its own enable vector. The SCI path uses the general-purpose event enable vector.

While the system sleeps, a latched event whose general-purpose event enable is set raises a wake request. The route code plays no part in this wake path.

Configuration goes through a small register port. The selector chooses one of four registers:

| Select | Register |
|--------|----------|
| 0 | Route register: 32 bits, two per input |
| 1 | Event status: write 1 to clear |
| 2 | SMI enable |
| 3 | Event enable |

Reads are combinational. Writes take effect at the clock edge on which `cfg_we` is high. All pins are plain levels and there is no handshake.

Top module: `gpi_router`

## Requirements
- R1: After reset, all four registers read zero, and `smi_o`, `sci_o` and `wake_o` are low.
- R2: The route field of input n sits in route-register bits 2n+1:2n and reads back as written.
- R3: For an input outside the implemented mask (by default only input 14 is left out), the route field reads as zero and ignores writes. With the defaults, writing all ones reads back 32'hCFFF_FFFF.
- R4: A status bit is set at the clock edge that samples a rising edge on its pin while `gpi_dir` for that pin is 1 (input). A pin that stays high sets it only once. A pin configured as an output (`gpi_dir`=0) never sets it.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a new edge arrives in the same cycle as a clear, the bit stays set.
- R6: Route code 00 raises neither SMI nor SCI.
- R7: Route code 01 drives `smi_o` high while the status bit and the SMI enable bit of that input are both set, and only then.
- R8: Route code 10 drives `sci_o` high while the status bit and the event enable bit of that input are both set, and only then.
- R9: Route code 11 is reserved and raises neither interrupt.
- R10: An input whose `gpi_dir` bit is 0 raises no interrupt, even when its status bit is set.
- R11: While `sleep_state` is nonzero, `wake_o` is high whenever any input has both its status bit and its event enable bit set, whatever its route code. While `sleep_state` is 0, `wake_o` is low.
- R12: `smi_o` and `sci_o` are ORs over all inputs. They stay high until the last qualifying status bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpi_pin | input | 16 | Pin levels |
| gpi_dir | input | 16 | 1 = pin configured as input |
| sleep_state | input | 3 | 0 = working, 1..5 = sleep states |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_sel` |
| smi_o | output | 1 | SMI level |
| sci_o | output | 1 | SCI level |
| wake_o | output | 1 | Wake request |

## Verification
The routing function is exercised on four inputs, one carrying each route code, with both enables set. Raising one event at a time separates the two interrupt paths from the silent codes 00 and 11. Clearing each enable in turn afterwards shows that the enable gates the route.

Three further patterns are used:
- A latched event on a pin switched to output is used to separate direction gating from status latching.
- A sleep-state sweep, with the event routed nowhere, shows that wake ignores the route code.
- Two events on the same path, cleared one at a time, tell an OR of levels apart from a single pulse.

// File: rtl/gpi_router_pkg.sv
package gpi_router_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_SMI  = 2'b01,
    RT_SCI  = 2'b10,
    RT_RSVD = 2'b11
  } route_e;

  typedef enum logic [1:0] {
    SEL_ROUTE = 2'd0,
    SEL_STS   = 2'd1,
    SEL_SMIEN = 2'd2,
    SEL_EVTEN = 2'd3
  } sel_e;
endpackage

// File: rtl/gpi_cfg_regs.sv
module gpi_cfg_regs
  import gpi_router_pkg::*;
#(
  parameter int          N_IN      = 16,
  parameter logic [15:0] IMPL_MASK = 16'hBFFF,
  localparam int         RW        = 2 * N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [RW-1:0]    wdata,
  output logic [RW-1:0]    route_q,
  output logic [N_IN-1:0]  smi_en_q,
  output logic [N_IN-1:0]  evt_en_q
);
  logic [RW-1:0] route_keep;

  // Expand the implemented-input mask to two bits per route field.
  for (genvar i = 0; i < N_IN; i++) begin : g_mask
    assign route_keep[2*i +: 2] = {2{IMPL_MASK[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q  <= '0;
      smi_en_q <= '0;
      evt_en_q <= '0;
    end else if (we) begin
      unique case (sel_e'(sel))
        SEL_ROUTE: route_q  <= wdata & route_keep;
        SEL_SMIEN: smi_en_q <= wdata[N_IN-1:0];
        SEL_EVTEN: evt_en_q <= wdata[N_IN-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpi_event_latch.sv
module gpi_event_latch #(
  parameter int N_IN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] pin,
  input  logic [N_IN-1:0] dir,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] rise,
  output logic [N_IN-1:0] sts_q
);
  logic [N_IN-1:0] pin_q;

  assign rise = pin & ~pin_q & dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= '0;
      sts_q <= '0;
    end else begin
      pin_q <= pin;
      // A new edge wins over a clear in the same cycle.
      sts_q <= (sts_q & ~clr) | rise;
    end
  end
endmodule

// File: rtl/gpi_route_logic.sv
module gpi_route_logic
  import gpi_router_pkg::*;
#(
  parameter int  N_IN = 16,
  localparam int RW   = 2 * N_IN
) (
  input  logic [RW-1:0]   route,
  input  logic [N_IN-1:0] sts,
  input  logic [N_IN-1:0] dir,
  input  logic [N_IN-1:0] smi_en,
  input  logic [N_IN-1:0] evt_en,
  input  logic [2:0]      sleep_state,
  output logic            smi,
  output logic            sci,
  output logic            wake
);
  logic [N_IN-1:0] smi_hit, sci_hit;

  for (genvar i = 0; i < N_IN; i++) begin : g_route
    route_e code;
    assign code       = route_e'(route[2*i +: 2]);
    assign smi_hit[i] = dir[i] & sts[i] & smi_en[i] & (code == RT_SMI);
    assign sci_hit[i] = dir[i] & sts[i] & evt_en[i] & (code == RT_SCI);
  end

  assign smi  = |smi_hit;
  assign sci  = |sci_hit;
  assign wake = (sleep_state != 3'd0) && |(sts & evt_en);
endmodule

// File: rtl/gpi_router.sv
module gpi_router
  import gpi_router_pkg::*;
#(
  parameter int          N_IN      = 16,
  parameter logic [15:0] IMPL_MASK = 16'hBFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] gpi_pin,
  input  logic [15:0] gpi_dir,
  input  logic [2:0]  sleep_state,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        smi_o,
  output logic        sci_o,
  output logic        wake_o
);
  localparam int RW = 2 * N_IN;

  logic [RW-1:0]   route_q;
  logic [N_IN-1:0] smi_en_q, evt_en_q, sts_q, rise, clr;

  assign clr = (cfg_we && cfg_sel == SEL_STS) ? cfg_wdata[N_IN-1:0] : '0;

  gpi_cfg_regs #(.N_IN(N_IN), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata[RW-1:0]),
    .route_q  (route_q),
    .smi_en_q (smi_en_q),
    .evt_en_q (evt_en_q)
  );

  gpi_event_latch #(.N_IN(N_IN)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (gpi_pin[N_IN-1:0]),
    .dir   (gpi_dir[N_IN-1:0]),
    .clr   (clr),
    .rise  (rise),
    .sts_q (sts_q)
  );

  gpi_route_logic #(.N_IN(N_IN)) u_route (
    .route       (route_q),
    .sts         (sts_q),
    .dir         (gpi_dir[N_IN-1:0]),
    .smi_en      (smi_en_q),
    .evt_en      (evt_en_q),
    .sleep_state (sleep_state),
    .smi         (smi_o),
    .sci         (sci_o),
    .wake        (wake_o)
  );

  always_comb begin
    cfg_rdata = '0;
    unique case (sel_e'(cfg_sel))
      SEL_ROUTE: cfg_rdata[RW-1:0]   = route_q;
      SEL_STS:   cfg_rdata[N_IN-1:0] = sts_q;
      SEL_SMIEN: cfg_rdata[N_IN-1:0] = smi_en_q;
      SEL_EVTEN: cfg_rdata[N_IN-1:0] = evt_en_q;
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpi_router_chk.sv
module gpi_router_chk #(
  parameter int          N_IN      = 16,
  parameter logic [15:0] IMPL_MASK = 16'hBFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       gpi_dir,
  input logic [2:0]        sleep_state,
  input logic              cfg_we,
  input logic              smi_o,
  input logic              sci_o,
  input logic              wake_o,
  input logic [2*N_IN-1:0] route_q,
  input logic [N_IN-1:0]   sts_q,
  input logic [N_IN-1:0]   rise,
  input logic [N_IN-1:0]   smi_en_q,
  input logic [N_IN-1:0]   evt_en_q
);
  logic [2*N_IN-1:0] unimpl;

  for (genvar i = 0; i < N_IN; i++) begin : g_um
    assign unimpl[2*i +: 2] = {2{~IMPL_MASK[i]}};
  end

  AST_WAKE_QUIET_S0: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == 3'd0) |-> !wake_o); // R11
  AST_SMI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> |(sts_q & smi_en_q & gpi_dir[N_IN-1:0])); // R7
  AST_SCI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> |(sts_q & evt_en_q & gpi_dir[N_IN-1:0])); // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & unimpl) == '0); // R3
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && rise == '0) |=> $stable(sts_q)); // R4
endmodule

bind gpi_router gpi_router_chk #(.N_IN(N_IN), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gpi_dir     (gpi_dir),
  .sleep_state (sleep_state),
  .cfg_we      (cfg_we),
  .smi_o       (smi_o),
  .sci_o       (sci_o),
  .wake_o      (wake_o),
  .route_q     (route_q),
  .sts_q       (sts_q),
  .rise        (rise),
  .smi_en_q    (smi_en_q),
  .evt_en_q    (evt_en_q)
);

// File: tb/tb_gpi_router.sv
module tb_gpi_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gpi_pin = '0;
  logic [15:0] gpi_dir = '0;
  logic [2:0]  sleep_state = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        smi_o, sci_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpi_router dut (
    .clk(clk), .rst_n(rst_n), .gpi_pin(gpi_pin), .gpi_dir(gpi_dir),
    .sleep_state(sleep_state), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_check(string req, logic [1:0] sel, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic pulse(int b);
    @(negedge clk); gpi_pin[b] = 1'b1;
    @(negedge clk); gpi_pin[b] = 1'b0;
  endtask

  task automatic clear_all();
    wr(2'd1, 32'hFFFF);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_reset();
    rd_check("R1 route", 2'd0, 32'h0);
    rd_check("R1 status", 2'd1, 32'h0);
    rd_check("R1 smien", 2'd2, 32'h0);
    rd_check("R1 evten", 2'd3, 32'h0);
    check("R1 outputs", {29'd0, smi_o, sci_o, wake_o}, 32'h0);
  endtask

  task automatic t_layout();
    wr(2'd0, 32'h1 << 10);               // input 5 code 01
    rd_check("R2 field5", 2'd0, 32'h0000_0400);
    wr(2'd0, 32'h2 << 30);               // input 15 code 10
    rd_check("R2 field15", 2'd0, 32'h8000_0000);
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R3 unimpl14", 2'd0, 32'hCFFF_FFFF);
    wr(2'd0, 32'h3000_0000);
    rd_check("R3 unimpl only", 2'd0, 32'h0);
  endtask

  task automatic t_status();
    gpi_dir = 16'hFFBF;                  // pin 6 is an output
    pulse(3);
    rd_check("R4 edge sets", 2'd1, 32'h0008);
    @(negedge clk); gpi_pin[4] = 1'b1;
    @(negedge clk); wr(2'd1, 32'h0010);
    rd_check("R4 held high once", 2'd1, 32'h0008);
    gpi_pin[4] = 1'b0;
    pulse(6);
    rd_check("R4 output pin", 2'd1, 32'h0008);
    wr(2'd1, 32'h0);
    rd_check("R5 write zero", 2'd1, 32'h0008);
    wr(2'd1, 32'h0008);
    rd_check("R5 w1c", 2'd1, 32'h0);
    @(negedge clk);
    gpi_pin[7] = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0080;
    @(negedge clk);
    cfg_we = 1'b0; gpi_pin[7] = 1'b0;
    rd_check("R5 set wins", 2'd1, 32'h0080);
    gpi_dir = 16'hFFFF;
    clear_all();
  endtask

  task automatic t_routes();
    wr(2'd0, 32'h0000_00E4);             // in0=00 in1=01 in2=10 in3=11
    wr(2'd2, 32'hFFFF);
    wr(2'd3, 32'hFFFF);
    pulse(0);
    check("R6 code00", {30'd0, smi_o, sci_o}, 32'h0);
    wr(2'd1, 32'hFFFF);
    pulse(3);
    check("R9 code11", {30'd0, smi_o, sci_o}, 32'h0);
    wr(2'd1, 32'hFFFF);
    pulse(1);
    check("R7 smi", {30'd0, smi_o, sci_o}, 32'h2);
    wr(2'd2, 32'hFFFD);
    #1 check("R7 smi gated", {31'd0, smi_o}, 32'h0);
    wr(2'd1, 32'hFFFF);
    pulse(2);
    check("R8 sci", {30'd0, smi_o, sci_o}, 32'h1);
    wr(2'd3, 32'hFFFB);
    #1 check("R8 sci gated", {31'd0, sci_o}, 32'h0);
    clear_all();
  endtask

  task automatic t_dir();
    wr(2'd0, 32'h0000_0004);             // in1 code 01
    wr(2'd2, 32'h0002);
    pulse(1);
    check("R10 input", {31'd0, smi_o}, 32'h1);
    @(negedge clk); gpi_dir[1] = 1'b0;
    #1 check("R10 output no int", {31'd0, smi_o}, 32'h0);
    gpi_dir[1] = 1'b1;
    clear_all();
  endtask

  task automatic t_wake();
    wr(2'd3, 32'h0001);                  // in0 route 00, event enable on
    pulse(0);
    check("R11 s0 no wake", {31'd0, wake_o}, 32'h0);
    for (int s = 1; s <= 5; s++) begin
      @(negedge clk); sleep_state = 3'(s);
      #1 check($sformatf("R11 wake s%0d", s), {31'd0, wake_o}, 32'h1);
    end
    wr(2'd3, 32'h0);
    #1 check("R11 en off", {31'd0, wake_o}, 32'h0);
    @(negedge clk); sleep_state = 3'd0;
    clear_all();
  endtask

  task automatic t_or_hold();
    wr(2'd0, 32'h0000_0404);             // in1, in5 code 01
    wr(2'd2, 32'h0022);
    pulse(1);
    pulse(5);
    repeat (4) @(negedge clk);
    check("R12 held", {31'd0, smi_o}, 32'h1);
    wr(2'd1, 32'h0002);
    #1 check("R12 one left", {31'd0, smi_o}, 32'h1);
    wr(2'd1, 32'h0020);
    #1 check("R12 all clear", {31'd0, smi_o}, 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    wr(2'd0, 32'h0);
    t_status();
    t_routes();
    t_dir();
    t_wake();
    t_or_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule